// File: doc/BRIEF.md
# Byte-Serial Block Permutation Register File

This block holds a 64-bit cipher data block as two 32-bit halves, left and right. Each half is built from four 8-bit shift registers. A block enters one byte per clock through an 8-bit port. Each input bit lane feeds a different one of the eight shift registers. After eight byte loads the halves therefore hold the block with the standard DES initial permutation applied, and this needs no crossbar, only wiring.

The result leaves one byte per clock through a registered 8-bit output. The same wiring, taken in reverse and with the roles of the halves exchanged, applies the inverse initial permutation to the pre-output block (right half first, then left half). A round datapath outside this block can read both halves in parallel at any time. It can also overwrite both halves in a single clock with a parallel-load enable, and that enable overrides any byte transfer in the same cycle.

A byte counter raises a one-cycle completion flag after every eighth accepted byte transfer.

Top module: `des_ip_regs`

## Requirements
- R1: A synchronous active-high reset clears both halves, the byte output, the completion flag and the byte counter, and all of them read zero in the cycle after reset.
- R2: Each clock with `load_en` high (and `pload_en` low) shifts one byte from `byte_in` into the registers. After eight loads of bytes B0..B7 (B0 first, and byte bit 7 is the block's first bit), `left_q` and `right_q` equal the DES initial permutation of the 64-bit block B0..B7, with bit 1 of the block at bit 31 of `left_q`.
- R3: Every one of the 64 block bit positions reaches exactly the bit of `left_q`/`right_q` that the initial permutation assigns to it, so a block with a single 1 (marching one) gives a single 1 in the halves at the permuted position.
- R4: With `pload_en` high, `left_q` and `right_q` take `left_d` and `right_d` in the next cycle.
- R5: `pload_en` takes priority over `load_en` and `unload_en` in the same cycle. Neither strobe then shifts, changes `byte_out` or counts, and the byte counter is cleared.
- R6: Each clock with `unload_en` high (and `load_en` and `pload_en` low) places on `byte_out`, in the next cycle, the next byte of the inverse initial permutation of the 64-bit value {`right_q`, `left_q`}, first byte first. Zeros fill the vacated positions.
- R7: When `load_en` and `unload_en` are both high, the load is performed and the unload is ignored, and `byte_out` holds its value.
- R8: `blk_done` is high for exactly one cycle, the cycle after the eighth accepted byte transfer (a load or an unload) since reset or since the last completion or parallel load.
- R9: In a cycle with no strobe, both halves and `byte_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Serial input byte |
| load_en | input | 1 | Shift one input byte in |
| unload_en | input | 1 | Shift one output byte out |
| pload_en | input | 1 | Parallel load of both halves |
| left_d | input | 32 | Parallel left half in |
| right_d | input | 32 | Parallel right half in |
| left_q | output | 32 | Left half, parallel read |
| right_q | output | 32 | Right half, parallel read |
| byte_out | output | 8 | Registered serial output byte |
| blk_done | output | 1 | One-cycle flag after eight byte transfers |

## Verification
The assertions assume that `load_en`, `unload_en` and `pload_en` are known, non-X values in every clock after reset. They also assume that the parallel inputs are only meaningful while `pload_en` is high. The stimulus drives every input on the falling edge and never leaves one undriven. It changes the parallel buses freely while `pload_en` is low, which also shows that those buses are ignored at that time. Conflicting strobe combinations are applied on purpose, in both directed and random phases, so that the priority properties are exercised rather than avoided.

// File: rtl/des_ip_pkg.sv
package des_ip_pkg;
  localparam int BYTE_W    = 8;
  localparam int HALF_REGS = 4;
  localparam int NREG      = 2 * HALF_REGS;
  localparam int HALF_W    = HALF_REGS * BYTE_W;
  localparam int CNT_W     = $clog2(NREG);

  // Input bit lane feeding shift register j (j 0..3 left bytes MSB first, 4..7 right).
  localparam int LOAD_LANE   [NREG] = '{6, 4, 2, 0, 7, 5, 3, 1};
  // Output bit lane driven by register j; halves exchange roles on the way out.
  localparam int UNLOAD_LANE [NREG] = '{7, 5, 3, 1, 6, 4, 2, 0};
endpackage

// File: rtl/ipr_byte_shreg.sv
module ipr_byte_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pld,
  input  logic [W-1:0] pd,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (pld)   q <= pd;
    else if (shift) q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/ipr_byte_counter.sv
module ipr_byte_counter #(
  parameter int LIMIT = 8,
  localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      if (cnt == CW'(LIMIT - 1)) begin
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/des_ip_regs.sv
module des_ip_regs
  import des_ip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              load_en,
  input  logic              unload_en,
  input  logic              pload_en,
  input  logic [HALF_W-1:0] left_d,
  input  logic [HALF_W-1:0] right_d,
  output logic [HALF_W-1:0] left_q,
  output logic [HALF_W-1:0] right_q,
  output logic [BYTE_W-1:0] byte_out,
  output logic              blk_done
);
  logic              do_load, do_unload, do_shift;
  logic [BYTE_W-1:0] tap;
  logic [BYTE_W-1:0] reg_q [NREG];

  assign do_load   = load_en && !pload_en;
  assign do_unload = unload_en && !load_en && !pload_en;
  assign do_shift  = do_load || do_unload;

  for (genvar j = 0; j < NREG; j++) begin : g_reg
    localparam int HB = HALF_REGS - 1 - (j % HALF_REGS);
    logic [BYTE_W-1:0] pbyte;
    if (j < HALF_REGS) begin : g_left
      assign pbyte = left_d[HB*BYTE_W +: BYTE_W];
      assign left_q[HB*BYTE_W +: BYTE_W] = reg_q[j];
    end else begin : g_right
      assign pbyte = right_d[HB*BYTE_W +: BYTE_W];
      assign right_q[HB*BYTE_W +: BYTE_W] = reg_q[j];
    end

    ipr_byte_shreg #(.W(BYTE_W)) u_sr (
      .clk   (clk),
      .rst   (rst),
      .pld   (pload_en),
      .pd    (pbyte),
      .shift (do_shift),
      .sin   (do_load & byte_in[LOAD_LANE[j]]),
      .q     (reg_q[j])
    );

    assign tap[UNLOAD_LANE[j]] = reg_q[j][0];
  end

  always_ff @(posedge clk) begin
    if (rst)            byte_out <= '0;
    else if (do_unload) byte_out <= tap;
  end

  ipr_byte_counter #(.LIMIT(NREG)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (pload_en),
    .step (do_shift),
    .done (blk_done)
  );
endmodule

// File: rtl/des_ip_regs_chk.sv
module des_ip_regs_chk
  import des_ip_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] byte_in,
  input logic              load_en,
  input logic              unload_en,
  input logic              pload_en,
  input logic [HALF_W-1:0] left_d,
  input logic [HALF_W-1:0] right_d,
  input logic [HALF_W-1:0] left_q,
  input logic [HALF_W-1:0] right_q,
  input logic [BYTE_W-1:0] byte_out,
  input logic              blk_done
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (left_q == '0 && right_q == '0 && byte_out == '0 && !blk_done));

  a_r4_parallel_load: assert property (@(posedge clk) disable iff (rst)
    pload_en |=> (left_q == $past(left_d) && right_q == $past(right_d)));

  a_r5_pload_no_out: assert property (@(posedge clk) disable iff (rst)
    pload_en |=> ($stable(byte_out) && !blk_done));

  a_r2_load_shift: assert property (@(posedge clk) disable iff (rst)
    (load_en && !pload_en) |=>
      (left_q[HALF_W-1] == $past(byte_in[LOAD_LANE[0]]) &&
       left_q[HALF_W-2:HALF_W-BYTE_W] == $past(left_q[HALF_W-1:HALF_W-BYTE_W+1])));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load_en && unload_en && !pload_en) |=> $stable(byte_out));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !unload_en && !pload_en) |=>
      ($stable(left_q) && $stable(right_q) && $stable(byte_out)));
endmodule

bind des_ip_regs des_ip_regs_chk u_chk (.*);

// File: tb/des_ip_regs_tb.sv
`timescale 1ns/1ps
module des_ip_regs_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  byte_in;
  logic        load_en, unload_en, pload_en;
  logic [31:0] left_d, right_d;
  logic [31:0] left_q, right_q;
  logic [7:0]  byte_out;
  logic        blk_done;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state
  logic [63:0] m_lr;
  logic [7:0]  m_out;
  int          m_cnt;
  logic        m_done;

  always #2 clk = ~clk;

  des_ip_regs u_dut (.*);

  // bit p (1..64, first bit = MSB) of the permuted block comes from source bit src
  function automatic int ip_src(input int p);
    int r, c;
    r = (p - 1) / 8;
    c = (p - 1) % 8;
    return (r < 4) ? (58 + 2*r - 8*c) : (57 + 2*(r-4) - 8*c);
  endfunction

  function automatic logic [63:0] ip_fwd(input logic [63:0] x);
    logic [63:0] y;
    for (int p = 1; p <= 64; p++) y[64-p] = x[64-ip_src(p)];
    return y;
  endfunction

  function automatic logic [63:0] ip_inv(input logic [63:0] x);
    logic [63:0] y;
    for (int p = 1; p <= 64; p++) y[64-ip_src(p)] = x[64-p];
    return y;
  endfunction

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one cycle: compare outputs at the falling edge, drive new inputs, advance model
  task automatic step(input logic r, input logic ld, input logic ul, input logic pl,
                      input logic [7:0] b, input logic [31:0] ld_l, input logic [31:0] ld_r);
    logic [63:0] v;
    chk({tag, " halves"}, {left_q, right_q}, m_lr);
    chk({tag, " byte_out"}, {56'h0, byte_out}, {56'h0, m_out});
    chk({tag, " blk_done"}, {63'h0, blk_done}, {63'h0, m_done});
    rst = r; load_en = ld; unload_en = ul; pload_en = pl;
    byte_in = b; left_d = ld_l; right_d = ld_r;
    if (r) begin
      m_lr = '0; m_out = '0; m_cnt = 0; m_done = 1'b0;
    end else if (pl) begin
      m_lr = {ld_l, ld_r}; m_cnt = 0; m_done = 1'b0;
    end else if (ld || ul) begin
      if (ld) begin
        v = ip_inv(m_lr);
        m_lr = ip_fwd({v[55:0], b});
      end else begin
        v = ip_inv({m_lr[31:0], m_lr[63:32]});
        m_out = v[63:56];
        v = {v[55:0], 8'h00};
        v = ip_fwd(v);
        m_lr = {v[31:0], v[63:32]};
      end
      m_done = (m_cnt == 7);
      m_cnt = (m_cnt + 1) % 8;
    end else begin
      m_done = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, $urandom, $urandom, $urandom);
  endtask

  task automatic load_block(input logic [63:0] blk);
    for (int k = 0; k < 8; k++) step(0, 1, 0, 0, blk[63-8*k -: 8], $urandom, $urandom);
  endtask

  initial begin
    logic [7:0] held;
    rst = 1; load_en = 0; unload_en = 0; pload_en = 0;
    byte_in = 0; left_d = 0; right_d = 0;
    m_lr = '0; m_out = '0; m_cnt = 0; m_done = 1'b0;
    @(negedge clk); @(negedge clk);

    // R1: reset state
    tag = "R1";
    step(1, 0, 0, 0, 8'h00, 0, 0);
    chk("R1 reset halves", {left_q, right_q}, 64'h0);
    chk("R1 reset done", {63'h0, blk_done}, 64'h0);

    // R2: known block and its permuted halves
    tag = "R2";
    load_block(64'h0123456789ABCDEF);
    chk("R2 known IP", {left_q, right_q}, 64'hCC00CCFF_F0AAF0AA);
    chk("R8 done after 8 loads", {63'h0, blk_done}, 64'h1);
    idle(1);

    // R3: marching one through every block position
    tag = "R3";
    for (int i = 0; i < 64; i++) begin
      load_block(64'h1 << i);
      checks++;
      if ($countones({left_q, right_q}) != 1) begin
        errors++;
        $display("FAIL R3 marching bit %0d actual=%h expected=one set bit", i, {left_q, right_q});
      end
    end

    // R6 + R8: unload a block in eight bytes
    tag = "R6";
    step(0, 0, 0, 1, 0, 32'h0A4C_D995, 32'h4342_3234);
    for (int k = 0; k < 8; k++) step(0, 0, 1, 0, $urandom, $urandom, $urandom);
    chk("R8 done after 8 unloads", {63'h0, blk_done}, 64'h1);
    idle(2);
    tag = "R6";
    for (int k = 0; k < 8; k++) step(0, 0, 1, 0, 0, 0, 0);
    chk("R6 drained halves are zero", {left_q, right_q}, 64'h0);

    // R4 + R5: parallel load beats the strobes and clears the count
    tag = "R5";
    load_block(64'hFEDCBA9876543210);
    step(0, 1, 0, 0, 8'h11, 0, 0);
    step(0, 1, 0, 0, 8'h22, 0, 0);
    held = byte_out;
    step(0, 1, 1, 1, 8'h33, 32'hDEAD_BEEF, 32'h1234_5678);
    chk("R4 parallel load", {left_q, right_q}, 64'hDEADBEEF_12345678);
    chk("R5 byte_out held", {56'h0, byte_out}, {56'h0, held});
    tag = "R8";
    for (int k = 0; k < 7; k++) step(0, 1, 0, 0, 8'h5A, 0, 0);
    chk("R8 no done after 7", {63'h0, blk_done}, 64'h0);
    step(0, 1, 0, 0, 8'hA5, 0, 0);
    chk("R8 done on 8th after clear", {63'h0, blk_done}, 64'h1);

    // R7: load and unload together
    tag = "R7";
    step(0, 0, 1, 0, 0, 0, 0);
    held = byte_out;
    step(0, 1, 1, 0, 8'hC3, 0, 0);
    chk("R7 byte_out held on load+unload", {56'h0, byte_out}, {56'h0, held});

    // R9: idle with noisy buses
    tag = "R9";
    idle(5);

    // mixed traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(0, 15);
      step(s == 0 && i % 97 == 0, s < 6, s >= 4 && s < 10, s == 10,
           $urandom, $urandom, $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule